// File: doc/BRIEF.md
# Halt-Exit Oscillator Startup Sequencer

This block decides when the rest of the chip gets its clocks back after a low-power halt. While the chip runs normally, both the oscillator enable and the core clock enable are high. A halt request turns both off. A wakeup request received while halted re-enables only the oscillator and starts a startup timer. The core clock stays gated until the oscillator has had time to settle.

The startup timer counts instruction-cycle ticks, each of which is ten oscillator clocks. It holds 256 tick counts; the counter is loaded with all ones and expires on the tick after it reaches zero. Oscillator clocks advance the prescaler only while a clock-valid qualifier is high. This qualifier stands in for an amplitude detector. A weak or stalled oscillator therefore stretches the delay instead of shortening it. A status output shows when the startup delay is in progress.

Top module: `halt_exit_seq`

## Requirements
- R1: After reset the block is in the running state: `osc_en`=1, `core_clk_en`=1, `in_startup`=0.
- R2: In the running state, `halt_req` sampled high at a clock edge moves the block to the halted state: from that edge on `osc_en`=0, `core_clk_en`=0, `in_startup`=0.
- R3: In the halted state, `wake_req` sampled high at a clock edge starts the startup delay: from that edge on `osc_en`=1, `core_clk_en`=0, `in_startup`=1.
- R4: On entry to the startup delay the divide-by-DIV prescaler restarts from zero, whatever phase it held before. The first tick therefore comes on the DIV-th qualified clock after entry.
- R5: The startup delay lasts exactly DIV*2^CNT_W qualified clock edges after the entry edge (2560 with defaults). `core_clk_en` stays 0 before the last of these edges and is 1 from that edge on, when the block returns to the running state.
- R6: A clock edge with `clk_ok`=0 advances neither the prescaler nor the startup counter.
- R7: `wake_req` has no effect in the running state or during the startup delay. In particular it does not restart the delay.
- R8: `halt_req` has no effect in the halted state or during the startup delay.
- R9: `in_startup` is 1 exactly while the startup delay is in progress. `core_clk_en` is never 1 while `osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ok | input | 1 | Oscillator amplitude qualified as valid |
| wake_req | input | 1 | Request to leave the halted state |
| halt_req | input | 1 | Request to enter the halted state |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Enable for clocks to the rest of the chip |
| in_startup | output | 1 | High while the startup delay runs |

## Verification
The hardest conditions to reach are a prescaler that holds a non-zero phase when the startup delay begins, and a delay that stretches when the clock qualifier drops out. Neither shows at the ports until the 2560th qualified edge. To reach the first, the bench runs the block for a few qualified clocks before halting, so the prescaler is mid-count at wakeup. To reach the second, it drives a gapped qualifier pattern and injects stray wake and halt pulses during the delay. In each case it counts only qualified edges and checks the exact edge on which the core clock returns.

// File: rtl/halt_exit_pkg.sv
package halt_exit_pkg;
   typedef enum logic [1:0] {
      HX_RUN     = 2'd0,
      HX_HALTED  = 2'd1,
      HX_STARTUP = 2'd2
   } hx_state_e;
endpackage

// File: rtl/hx_prescaler.sv
// Divide-by-DIV tick generator; advances only on qualified edges.
module hx_prescaler #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_pass
         logic unused_pins;
         assign unused_pins = ^{clk, rst_n, clr};
         assign tick = adv;
      end else begin : g_cnt
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ph_q <= '0;
            else if (clr)
               ph_q <= '0;
            else if (adv)
               ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
         end
         assign tick = adv && (ph_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/hx_startup_cnt.sv
// Down counter loaded with all ones; expires on the tick seen at zero.
module hx_startup_cnt #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic expire
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '1;
      else if (load)
         cnt_q <= '1;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire = tick && (cnt_q == '0);
endmodule

// File: rtl/halt_exit_seq.sv
module halt_exit_seq
   import halt_exit_pkg::*;
#(
   parameter int DIV   = 10,
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_ok,
   input  logic wake_req,
   input  logic halt_req,
   output logic osc_en,
   output logic core_clk_en,
   output logic in_startup
);
   generate
      if (DIV < 1 || DIV > 1024) begin : g_bad_div
         $error("halt_exit_seq: DIV out of range");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("halt_exit_seq: CNT_W out of range");
      end
   endgenerate

   hx_state_e state_q, state_d;
   logic      enter_su;
   logic      adv;
   logic      pre_tick;
   logic      su_tick;
   logic      su_done;

   assign enter_su = (state_q == HX_HALTED) && wake_req;
   assign adv      = osc_en && clk_ok;
   assign su_tick  = pre_tick && (state_q == HX_STARTUP);

   hx_prescaler #(.DIV(DIV)) pre_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (enter_su),
      .adv  (adv),
      .tick (pre_tick)
   );

   hx_startup_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (enter_su),
      .tick  (su_tick),
      .expire(su_done)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         HX_RUN:     if (halt_req) state_d = HX_HALTED;
         HX_HALTED:  if (wake_req) state_d = HX_STARTUP;
         HX_STARTUP: if (su_done)  state_d = HX_RUN;
         default:    state_d = HX_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= HX_RUN;
      else
         state_q <= state_d;
   end

   assign osc_en      = (state_q != HX_HALTED);
   assign core_clk_en = (state_q == HX_RUN);
   assign in_startup  = (state_q == HX_STARTUP);
endmodule

// File: rtl/halt_exit_seq_chk.sv
module halt_exit_seq_chk #(
   parameter int DIV   = 10,
   parameter int CNT_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic clk_ok,
   input logic wake_req,
   input logic halt_req,
   input logic osc_en,
   input logic core_clk_en,
   input logic in_startup
);
   localparam int TOTAL = DIV * (2 ** CNT_W);
   localparam int QW    = $clog2(TOTAL + 1);

   logic [QW-1:0] qcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         qcnt_q <= '0;
      else if (!in_startup)
         qcnt_q <= '0;
      else if (clk_ok)
         qcnt_q <= qcnt_q + 1'b1;
   end

   assert_halt_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en && halt_req |=> !osc_en && !core_clk_en && !in_startup);

   assert_wake_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en && wake_req |=> in_startup && osc_en && !core_clk_en);

   assert_core_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_startup |-> osc_en && !core_clk_en);

   assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_startup |-> qcnt_q < QW'(TOTAL));

   assert_exit_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_startup) |-> core_clk_en && (qcnt_q == QW'(TOTAL)));

   assert_unqual_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_startup && !clk_ok |=> in_startup);

   assert_run_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en && !halt_req |=> core_clk_en);

   assert_halted_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en && !wake_req |=> !osc_en);

   assert_enable_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> osc_en && !in_startup);
endmodule

bind halt_exit_seq halt_exit_seq_chk #(.DIV(DIV), .CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_ok     (clk_ok),
   .wake_req   (wake_req),
   .halt_req   (halt_req),
   .osc_en     (osc_en),
   .core_clk_en(core_clk_en),
   .in_startup (in_startup)
);

// File: tb/halt_exit_seq_tb_top.sv
module halt_exit_seq_tb_top;
   localparam int DIV   = 10;
   localparam int CNT_W = 8;
   localparam int TOTAL = DIV * (2 ** CNT_W);
   localparam int RUN_C = 6;   // {osc_en, core_clk_en, in_startup}
   localparam int HLT_C = 0;
   localparam int SU_C  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_ok = 1'b0;
   logic wake_req = 1'b0;
   logic halt_req = 1'b0;
   logic osc_en, core_clk_en, in_startup;

   int vectors = 0;
   int miscmp  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   halt_exit_seq #(.DIV(DIV), .CNT_W(CNT_W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_ok     (clk_ok),
      .wake_req   (wake_req),
      .halt_req   (halt_req),
      .osc_en     (osc_en),
      .core_clk_en(core_clk_en),
      .in_startup (in_startup)
   );

   function automatic int outs();
      return {29'd0, osc_en, core_clk_en, in_startup};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscmp++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive at negedge, let one posedge pass, return at the next negedge
   task automatic step(input bit ok, input bit wk, input bit ht);
      clk_ok   = ok;
      wake_req = wk;
      halt_req = ht;
      @(posedge clk);
      @(negedge clk);
      wake_req = 1'b0;
      halt_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset outputs", outs(), RUN_C);
   endtask

   task automatic t_wake_in_run();
      step(1'b1, 1'b1, 1'b0);
      chk("R7 wake ignored in run", outs(), RUN_C);
      for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0); // prescaler off zero
      chk("R1 still running", outs(), RUN_C);
   endtask

   task automatic t_halt();
      step(1'b1, 1'b0, 1'b1);
      chk("R2 halt gates both enables", outs(), HLT_C);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
      chk("R8 halt ignored while halted", outs(), HLT_C);
   endtask

   task automatic t_wake();
      step(1'b1, 1'b1, 1'b0);
      chk("R3 wake starts delay", outs(), SU_C);
   endtask

   // wake already applied; all edges qualified, prescaler held a non-zero phase
   task automatic t_full_delay();
      for (int q = 1; q < TOTAL; q++) begin
         step(1'b1, 1'b0, 1'b0);
         if (q % 512 == 0) chk("R5 core gated mid-delay", outs(), SU_C);
      end
      chk("R4 R5 still in delay one edge before end", outs(), SU_C);
      step(1'b1, 1'b0, 1'b0);
      chk("R5 R9 clocks released on last edge", outs(), RUN_C);
   endtask

   // gapped qualifier with stray requests during the delay
   task automatic t_gapped_delay();
      int q = 0;
      int cyc = 0;
      while (q < TOTAL - 1) begin
         bit ok = (cyc % 3) != 0;
         bit wk = (cyc % 701) == 350;
         bit ht = (cyc % 911) == 455;
         step(ok, wk, ht);
         if (ok) q++;
         cyc++;
      end
      chk("R7 R8 stray requests did not alter delay", outs(), SU_C);
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0);
      chk("R6 unqualified edges do not expire delay", outs(), SU_C);
      step(1'b1, 1'b0, 1'b0);
      chk("R6 R5 release after last qualified edge", outs(), RUN_C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wake_in_run();
      t_halt();
      t_wake();
      step(1'b0, 1'b1, 1'b0);
      chk("R7 wake ignored in delay", outs(), SU_C);
      t_full_delay();
      t_halt();
      t_wake();
      t_gapped_delay();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         vectors++;
         miscmp++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   end
endmodule